// File: doc/BRIEF.md
# Linked Descriptor Chain DMA Engine

This block is one DMA channel that runs a chain of transfer descriptors kept in memory. Software loads the address of the first descriptor into the chain pointer and pulses `go`. The engine then reads four 32-bit words from that address through a single read port. The words are the link, the source address, the target address and the command. It then copies the programmed number of bytes from source to target. Each beat is one read followed by one write, and each beat is as wide as the command's width field.

When a descriptor finishes, the engine checks bit 0 of its link word. If the bit is set, the channel stops. Otherwise it fetches the next descriptor from the link address with its low four bits cleared. A link that points back to an earlier descriptor makes an endless ring, which produces an end event on every pass. The live source and target addresses are always visible on output ports, so software can work out how many bytes remain. One-cycle event pulses mark the start of a descriptor, the end of a descriptor and a channel stop.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset `busy`, `stopped` and `bus_err` are 0, and no read or write request is raised.
- R2: A `go` pulse while idle sets `busy` and reads the descriptor words in this order: link, source, target, command. They are read at pointer+0, +4, +8 and +12.
- R3: Command bit 31 adds the beat size to the source address after every beat, and command bit 30 does the same for the target address. A clear bit holds that address. Both addresses are always visible on `src_addr` and `dst_addr`.
- R4: Command bits 15:14 choose the beat size: code 1 is 1 byte, code 2 is 2 bytes, and codes 3 and 0 are 4 bytes. A descriptor takes ceil(length / size) beats, and `wr_size` carries the code.
- R5: Command bits 12:0 hold the byte length. A length of zero moves no data and goes straight to the link decision.
- R6: Command bit 22 gives one `ev_start` pulse after the command word is read. Command bit 21 gives one `ev_end` pulse when that descriptor completes.
- R7: If link bit 0 is set, the engine clears `busy`, sets `stopped` and pulses `ev_stop`. Otherwise the next descriptor is fetched from the link word with bits 3:0 cleared.
- R8: A link that points back into the chain keeps the channel busy forever, with one `ev_end` per pass. Changing the stop bit in memory ends the ring.
- R9: If command bit 29 or bit 28 is set, no data read starts until `dreq` is high.
- R10: When `align_en` is 0, bits 2:0 of the loaded source and target addresses are forced to zero. When it is 1, the addresses are kept as written.
- R11: A read returning `rd_err` sets `bus_err`, clears `busy`, leaves `stopped` at 0 and halts the channel.
- R12: While `busy`, `go` and `ptr_we` have no effect, and a stopped channel stays idle until `go` is pulsed again.
- R13: A raised `rd_req` or `wr_req` stays high, with its address and data held, until `rd_valid` or `wr_ack` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_we | input | 1 | Load chain pointer while idle |
| ptr_in | input | ADDR_W | First descriptor address |
| go | input | 1 | Start pulse |
| align_en | input | 1 | Allow addresses not aligned to 8 bytes |
| dreq | input | 1 | Peripheral ready for a paced beat |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| rd_err | input | 1 | Read response error |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Write data |
| wr_size | output | 2 | Beat width code |
| wr_ack | input | 1 | Write accepted |
| src_addr | output | ADDR_W | Live source address |
| dst_addr | output | ADDR_W | Live target address |
| busy | output | 1 | Channel running |
| stopped | output | 1 | Chain ended on a stop link |
| bus_err | output | 1 | Read error seen |
| ev_start | output | 1 | Descriptor start event |
| ev_end | output | 1 | Descriptor end event |
| ev_stop | output | 1 | Channel stop event |

## Verification
`busy` rises on the edge that samples `go`. `ev_start` follows one edge after the command word's response. Address registers step on the edge that takes `wr_ack`. `ev_end` comes one edge after the final write, and `ev_stop` comes with it in the same cycle, together with `busy` falling. The bench's memory model answers on falling edges after a programmable latency and logs every request it serves. It counts event pulses on every falling edge. Checks are made only after `busy` has dropped, or after a fixed wait, so the logs and counters are final when compared.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PACE,
        ST_XRD,
        ST_XWR,
        ST_LINK
    } dcd_state_e;

    localparam int BIT_INC_SRC   = 31;
    localparam int BIT_INC_DST   = 30;
    localparam int BIT_PACE_SRC  = 29;
    localparam int BIT_PACE_DST  = 28;
    localparam int BIT_EV_START  = 22;
    localparam int BIT_EV_END    = 21;
    localparam int BIT_WIDTH_LO  = 14;
    localparam int WORD_BYTES    = 4;
endpackage

// File: rtl/dcd_addr_step.sv
module dcd_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic              inc_i,
    input  logic [2:0]        unit_i,
    output logic [ADDR_W-1:0] nxt_o
);
    always_comb begin
        nxt_o = inc_i ? cur_i + ADDR_W'(unit_i) : cur_i;
    end
endmodule

// File: rtl/dcd_beat_calc.sv
module dcd_beat_calc #(
    parameter int LEN_W = 13
) (
    input  logic [1:0]       width_i,
    input  logic [LEN_W-1:0] rem_i,
    output logic [2:0]       unit_o,
    output logic [LEN_W-1:0] rem_nxt_o,
    output logic             last_o
);
    logic [LEN_W-1:0] unit_ext;

    always_comb begin
        case (width_i)
            2'd1:    unit_o = 3'd1;
            2'd2:    unit_o = 3'd2;
            default: unit_o = 3'd4;
        endcase
        unit_ext  = LEN_W'(unit_o);
        last_o    = (rem_i <= unit_ext);
        rem_nxt_o = last_o ? '0 : rem_i - unit_ext;
    end
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic [ADDR_W-1:0] ptr_in,
    input  logic              go,
    input  logic              align_en,
    input  logic              dreq,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    input  logic              rd_err,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic [1:0]        wr_size,
    input  logic              wr_ack,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              busy,
    output logic              stopped,
    output logic              bus_err,
    output logic              ev_start,
    output logic              ev_end,
    output logic              ev_stop
);
    localparam logic [ADDR_W-1:0] DESC_MASK  = ~ADDR_W'(15);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(7);
    localparam int                N_PTR      = 2;

    typedef struct packed {
        dcd_state_e        st;
        logic [1:0]        widx;
        logic [ADDR_W-1:0] dptr;
        logic [ADDR_W-1:0] link_nxt;
        logic              link_stop;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              inc_s;
        logic              inc_d;
        logic              paced;
        logic              irq_end;
        logic [1:0]        width;
        logic [LEN_W-1:0]  rem;
        logic [31:0]       data;
        logic              busy;
        logic              stopped;
        logic              berr;
        logic              ev_start;
        logic              ev_end;
        logic              ev_stop;
    } dcd_regs_t;

    dcd_regs_t q, d;

    logic [2:0]        unit;
    logic [LEN_W-1:0]  rem_nxt;
    logic              last_beat;
    logic [ADDR_W-1:0] step_cur [N_PTR];
    logic              step_inc [N_PTR];
    logic [ADDR_W-1:0] step_nxt [N_PTR];
    logic [ADDR_W-1:0] rd_word_addr;

    dcd_beat_calc #(.LEN_W(LEN_W)) u_beat (
        .width_i   (q.width),
        .rem_i     (q.rem),
        .unit_o    (unit),
        .rem_nxt_o (rem_nxt),
        .last_o    (last_beat)
    );

    assign step_cur[0] = q.src;
    assign step_inc[0] = q.inc_s;
    assign step_cur[1] = q.dst;
    assign step_inc[1] = q.inc_d;

    for (genvar g = 0; g < N_PTR; g++) begin : g_step
        dcd_addr_step #(.ADDR_W(ADDR_W)) u_step (
            .cur_i  (step_cur[g]),
            .inc_i  (step_inc[g]),
            .unit_i (unit),
            .nxt_o  (step_nxt[g])
        );
    end

    function automatic logic [ADDR_W-1:0] fix_align(input logic [ADDR_W-1:0] a,
                                                     input logic en);
        return en ? a : (a & ALIGN_MASK);
    endfunction

    assign rd_word_addr = q.dptr + ADDR_W'({q.widx, 2'b00});

    always_comb begin
        d          = q;
        d.ev_start = 1'b0;
        d.ev_end   = 1'b0;
        d.ev_stop  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (ptr_we) d.dptr = ptr_in & DESC_MASK;
                if (go) begin
                    d.st      = ST_FETCH;
                    d.widx    = 2'd0;
                    d.busy    = 1'b1;
                    d.stopped = 1'b0;
                    d.berr    = 1'b0;
                end
            end
            ST_FETCH: begin
                if (rd_valid) begin
                    if (rd_err) begin
                        d.st   = ST_IDLE;
                        d.busy = 1'b0;
                        d.berr = 1'b1;
                    end else begin
                        d.widx = q.widx + 2'd1;
                        case (q.widx)
                            2'd0: begin
                                d.link_nxt  = rd_data[ADDR_W-1:0] & DESC_MASK;
                                d.link_stop = rd_data[0];
                            end
                            2'd1: d.src = fix_align(rd_data[ADDR_W-1:0], align_en);
                            2'd2: d.dst = fix_align(rd_data[ADDR_W-1:0], align_en);
                            default: begin
                                d.inc_s    = rd_data[BIT_INC_SRC];
                                d.inc_d    = rd_data[BIT_INC_DST];
                                d.paced    = rd_data[BIT_PACE_SRC] | rd_data[BIT_PACE_DST];
                                d.irq_end  = rd_data[BIT_EV_END];
                                d.width    = rd_data[BIT_WIDTH_LO+1:BIT_WIDTH_LO];
                                d.rem      = rd_data[LEN_W-1:0];
                                d.ev_start = rd_data[BIT_EV_START];
                                d.st       = (rd_data[LEN_W-1:0] == '0) ? ST_LINK : ST_PACE;
                            end
                        endcase
                    end
                end
            end
            ST_PACE: begin
                if (!q.paced || dreq) d.st = ST_XRD;
            end
            ST_XRD: begin
                if (rd_valid) begin
                    if (rd_err) begin
                        d.st   = ST_IDLE;
                        d.busy = 1'b0;
                        d.berr = 1'b1;
                    end else begin
                        d.data = rd_data;
                        d.st   = ST_XWR;
                    end
                end
            end
            ST_XWR: begin
                if (wr_ack) begin
                    d.src = step_nxt[0];
                    d.dst = step_nxt[1];
                    d.rem = rem_nxt;
                    d.st  = last_beat ? ST_LINK : ST_PACE;
                end
            end
            ST_LINK: begin
                d.ev_end = q.irq_end;
                if (q.link_stop) begin
                    d.st      = ST_IDLE;
                    d.busy    = 1'b0;
                    d.stopped = 1'b1;
                    d.ev_stop = 1'b1;
                end else begin
                    d.dptr = q.link_nxt;
                    d.widx = 2'd0;
                    d.st   = ST_FETCH;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_req   = (q.st == ST_FETCH) || (q.st == ST_XRD);
    assign rd_addr  = (q.st == ST_FETCH) ? rd_word_addr : q.src;
    assign wr_req   = (q.st == ST_XWR);
    assign wr_addr  = q.dst;
    assign wr_data  = q.data;
    assign wr_size  = q.width;
    assign src_addr = q.src;
    assign dst_addr = q.dst;
    assign busy     = q.busy;
    assign stopped  = q.stopped;
    assign bus_err  = q.berr;
    assign ev_start = q.ev_start;
    assign ev_end   = q.ev_end;
    assign ev_stop  = q.ev_stop;
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              stopped,
    input logic              bus_err,
    input logic              ev_stop,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_req,
    input logic              wr_ack,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data
);
    // R13: an unanswered read keeps its request and address
    p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

    // R13: an unanswered write keeps its request, address and data
    p_wr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

    // R7: the stop event comes with the stopped state and not busy
    p_stop_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |-> stopped && !busy);

    // R7: a channel is never busy and stopped at once
    p_stop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && stopped));

    // R11: a bus error leaves the channel halted
    p_err_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> !busy && !stopped);

    // R1: an idle channel raises no memory traffic
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req && !wr_req);
endmodule

bind desc_chain_dma dcd_checker #(.ADDR_W(ADDR_W)) u_dcd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .stopped  (stopped),
    .bus_err  (bus_err),
    .ev_stop  (ev_stop),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .wr_req   (wr_req),
    .wr_ack   (wr_ack),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/tb_desc_chain_dma.sv
module tb_desc_chain_dma;
    localparam int AW = 32;
    localparam logic [31:0] INC_S  = 32'h8000_0000;
    localparam logic [31:0] INC_D  = 32'h4000_0000;
    localparam logic [31:0] PACE_S = 32'h2000_0000;
    localparam logic [31:0] IRQ_S  = 32'h0040_0000;
    localparam logic [31:0] IRQ_E  = 32'h0020_0000;
    localparam logic [31:0] W2     = 32'h0000_8000;
    localparam logic [31:0] W4     = 32'h0000_C000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ptr_we = 1'b0;
    logic [AW-1:0] ptr_in = '0;
    logic go = 1'b0;
    logic align_en = 1'b1;
    logic dreq = 1'b1;
    logic rd_req, wr_req;
    logic [AW-1:0] rd_addr, wr_addr, src_addr, dst_addr;
    logic rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic rd_err = 1'b0;
    logic [31:0] wr_data;
    logic [1:0] wr_size;
    logic wr_ack = 1'b0;
    logic busy, stopped, bus_err, ev_start, ev_end, ev_stop;

    always #2.5 clk = ~clk;

    desc_chain_dma dut (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_in(ptr_in), .go(go),
        .align_en(align_en), .dreq(dreq), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size),
        .wr_ack(wr_ack), .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy),
        .stopped(stopped), .bus_err(bus_err), .ev_start(ev_start),
        .ev_end(ev_end), .ev_stop(ev_stop)
    );

    logic [31:0] mem [0:255];
    logic [31:0] rlog [0:63];
    logic [31:0] wlog_a [0:63];
    logic [31:0] wlog_d [0:63];
    logic [1:0]  wlog_s [0:63];
    int rn = 0, wn = 0, n_st = 0, n_end = 0, n_stop = 0;
    int rd_lat = 0, rd_cnt = 0;
    logic err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int n_cmp = 0, n_bad = 0;

    // memory model and event counting on falling edges
    always @(negedge clk) begin
        if (ev_start) n_st++;
        if (ev_end) n_end++;
        if (ev_stop) n_stop++;
        if (rd_valid) begin
            rd_valid <= 1'b0;
            rd_err   <= 1'b0;
            rd_cnt   <= 0;
        end else if (rd_req) begin
            if (rd_cnt >= rd_lat) begin
                rd_valid <= 1'b1;
                rd_data  <= mem[rd_addr[9:2]];
                rd_err   <= err_en && (rd_addr == err_addr);
                if (rn < 64) rlog[rn] <= rd_addr;
                rn++;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
        if (wr_ack) begin
            wr_ack <= 1'b0;
        end else if (wr_req) begin
            wr_ack <= 1'b1;
            if (wn < 64) begin
                wlog_a[wn] <= wr_addr;
                wlog_d[wn] <= wr_data;
                wlog_s[wn] <= wr_size;
            end
            wn++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic put_desc(input int base, input logic [31:0] lnk, input logic [31:0] s,
                            input logic [31:0] t, input logic [31:0] c);
        mem[base/4]     = lnk;
        mem[base/4 + 1] = s;
        mem[base/4 + 2] = t;
        mem[base/4 + 3] = c;
    endtask

    task automatic clear_logs();
        @(negedge clk);
        rn = 0; wn = 0; n_st = 0; n_end = 0; n_stop = 0;
    endtask

    task automatic start(input logic [31:0] p, input bit load);
        if (load) begin
            @(negedge clk); ptr_we = 1'b1; ptr_in = p;
            @(negedge clk); ptr_we = 1'b0;
        end
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    task automatic wait_idle();
        int c = 0;
        while (busy && c < 2000) begin
            @(negedge clk);
            c++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !stopped && !bus_err, "R1 status", {busy, stopped, bus_err}, 0);
        chk(!rd_req && !wr_req, "R1 requests", {rd_req, wr_req}, 0);
    endtask

    task automatic t_single();
        put_desc('h40, 32'h1, 32'h100, 32'h200, INC_S | INC_D | IRQ_S | IRQ_E | W4 | 12);
        rd_lat = 3;
        clear_logs();
        start(32'h40, 1);
        wait_idle();
        for (int i = 0; i < 4; i++)
            chk(rlog[i] == 32'h40 + 4 * i, "R2 fetch order", rlog[i], 32'h40 + 4 * i);
        chk(wn == 3, "R4 beat count w4", wn, 3);
        for (int i = 0; i < 3; i++) begin
            chk(wlog_a[i] == 32'h200 + 4 * i, "R3 dst step", wlog_a[i], 32'h200 + 4 * i);
            chk(wlog_d[i] == 32'hA000_0040 + i, "R3 data copy", wlog_d[i], 32'hA000_0040 + i);
        end
        chk(src_addr == 32'h10C && dst_addr == 32'h20C, "R3 live addr", src_addr, 32'h10C);
        chk(n_st == 1 && n_end == 1, "R6 events", {n_st[15:0], n_end[15:0]}, 32'h0001_0001);
        chk(stopped && !busy && n_stop == 1, "R7 stop", {stopped, busy}, 2'b10);
        rd_lat = 0;
    endtask

    task automatic t_width2();
        put_desc('h40, 32'h1, 32'h180, 32'h300, INC_D | W2 | 5);
        clear_logs();
        start(32'h40, 1);
        wait_idle();
        chk(wn == 3, "R4 ceil beats w2", wn, 3);
        chk(wlog_a[2] == 32'h304 && wlog_s[0] == 2'd2, "R4 size code", wlog_a[2], 32'h304);
        chk(src_addr == 32'h180, "R3 src held", src_addr, 32'h180);
        chk(dst_addr == 32'h306, "R3 dst w2", dst_addr, 32'h306);
        chk(n_st == 0 && n_end == 0, "R6 no events", n_st + n_end, 0);
    endtask

    task automatic t_chain();
        put_desc('h40, 32'h68, 32'h100, 32'h200, INC_S | INC_D | IRQ_E | W4 | 0);
        put_desc('h60, 32'h61, 32'h110, 32'h220, INC_S | INC_D | IRQ_E | W4 | 8);
        clear_logs();
        start(32'h40, 1);
        wait_idle();
        chk(rlog[4] == 32'h60, "R7 link masked", rlog[4], 32'h60);
        chk(wn == 2, "R5 zero length no data", wn, 2);
        chk(wlog_a[0] == 32'h220, "R5 second desc data", wlog_a[0], 32'h220);
        chk(n_end == 2 && n_stop == 1, "R6 end per desc", n_end, 2);
    endtask

    task automatic t_ring();
        int c = 0;
        put_desc('h80, 32'h80, 32'h100, 32'h200, INC_S | INC_D | IRQ_E | W4 | 8);
        clear_logs();
        start(32'h80, 1);
        while (n_end < 3 && c < 1000) begin
            @(negedge clk);
            c++;
        end
        chk(n_end >= 3 && busy, "R8 ring keeps running", n_end, 3);
        mem['h80/4] = 32'h81;
        wait_idle();
        chk(stopped && n_end >= 4 && n_stop == 1, "R8 ring ends", n_end, 4);
        chk(wlog_a[wn-1] == 32'h204, "R8 pass restarts", wlog_a[wn-1], 32'h204);
    endtask

    task automatic t_pace_ignore();
        put_desc('h40, 32'h41, 32'h100, 32'h200, INC_D | PACE_S | W4 | 4);
        put_desc('hC0, 32'hC1, 32'h100, 32'h280, INC_D | W4 | 4);
        dreq = 1'b0;
        clear_logs();
        start(32'h40, 1);
        repeat (30) @(negedge clk);
        chk(wn == 0 && rn == 4 && busy, "R9 waits for dreq", rn, 4);
        ptr_we = 1'b1; ptr_in = 32'hC0; go = 1'b1;
        @(negedge clk);
        ptr_we = 1'b0; go = 1'b0;
        dreq = 1'b1;
        wait_idle();
        chk(wn == 1 && wlog_a[0] == 32'h200, "R9 runs after dreq", wlog_a[0], 32'h200);
        repeat (10) @(negedge clk);
        chk(!busy && stopped, "R12 stays stopped", busy, 0);
        clear_logs();
        start(32'h0, 0);
        wait_idle();
        chk(rlog[0] == 32'h40, "R12 ptr write ignored", rlog[0], 32'h40);
    endtask

    task automatic t_align();
        put_desc('h40, 32'h41, 32'h104, 32'h20C, W4 | 4);
        align_en = 1'b0;
        clear_logs();
        start(32'h40, 1);
        wait_idle();
        chk(src_addr == 32'h100 && dst_addr == 32'h208, "R10 forced align", src_addr, 32'h100);
        align_en = 1'b1;
        start(32'h40, 0);
        wait_idle();
        chk(src_addr == 32'h104 && dst_addr == 32'h20C, "R10 unaligned kept", src_addr, 32'h104);
    endtask

    task automatic t_error();
        put_desc('h40, 32'h41, 32'h100, 32'h200, INC_D | W4 | 4);
        err_en = 1'b1; err_addr = 32'h48;
        clear_logs();
        start(32'h40, 1);
        wait_idle();
        chk(bus_err && !busy && !stopped, "R11 halt", {bus_err, busy, stopped}, 3'b100);
        chk(wn == 0 && n_stop == 0 && rn == 3, "R11 no more reads", rn, 3);
        err_en = 1'b0;
        start(32'h40, 0);
        wait_idle();
        chk(!bus_err && stopped && wn == 1, "R11 restart clears", bus_err, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_width2();
        t_chain();
        t_ring();
        t_pace_ignore();
        t_align();
        t_error();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end
endmodule